// File: doc/BRIEF.md
# UART Receive Event Interrupt Combiner

This block gathers the status events produced by a UART receiver and merges them into a single interrupt request line. There are four sources: receive errors, changes of the break level, control characters in received data, and wake-up detection. The receive-error source covers parity, overrun and framing errors. The block finds break edges and control characters itself. Every source sets a sticky flag, and the flag stays set until software clears it.

Software programs the four per-source enables with one byte write and clears flags with write-one-to-clear strobes. The interrupt line is registered. It goes high one cycle after any flag whose enable bit is set. A flag still records its event while its source is disabled, so enabling the source later raises the request at once.

Top module: `uirq_rx_event`

## Requirements
- R1: After reset all flags, all enables and the interrupt output are 0.
- R2: When `ctrlWe` is high, the enables load from `ctrlData` on that edge. Bit 4 enables the error source, bit 5 the break source, bit 6 the control-character source and bit 7 the wake-up source. Bits 3..0 are ignored.
- R3: A parity, overrun or framing error strobe sets flag bit 0 on the next clock edge.
- R4: Flag bit 1 is set on the edge where `breakLevel` differs from its value at the previous edge. Both rising and falling changes count. The remembered level is 0 after reset.
- R5: When `rxValid` is high and `rxByte` is 0x00..0x1F or 0x7F, flag bit 2 is set on that edge. Other byte values, and any byte while `rxValid` is low, leave the flag unchanged.
- R6: A high `wakeDetect` sets flag bit 3 on the next edge.
- R7: A flag stays set until a 1 is written to the same bit of `flagClr`. If a new event for that source arrives in the same cycle as the clear, the flag stays set.
- R8: `irq` at edge k+1 equals the OR over all sources of (flag AND enable) as held after edge k. This is one registered cycle of latency.
- R9: A flag whose enable is 0 still sets but never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Write strobe for the enable byte |
| ctrlData | input | 8 | Enable byte, with enables in bits 7..4 |
| flagClr | input | 4 | Write-one-to-clear for flags (0 err, 1 break, 2 ctrl char, 3 wake) |
| parityErr | input | 1 | Parity error strobe |
| overrunErr | input | 1 | Overrun error strobe |
| framingErr | input | 1 | Framing error strobe |
| breakLevel | input | 1 | Current break condition level |
| rxByte | input | 8 | Received character |
| rxValid | input | 1 | Qualifies `rxByte` for one cycle |
| wakeDetect | input | 1 | Wake-up detect condition |
| flags | output | 4 | Sticky event flags |
| irq | output | 1 | Registered interrupt request |

## Verification
Directed patterns cover several cases. A wake-up arriving with its source disabled separates flag setting from interrupt gating. The pair 0x41 and 0x7F probes both sides of the control-character range. A break held high, cleared and then dropped shows that only edges set the flag, in either direction. A clear that coincides with an overrun shows that the event wins over the clear. A long run of sparse random events, clears and enable rewrites is then compared every cycle against a behavioural model, which exposes wrong latency or cross-wired sources.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_ERR = 0;
  localparam int SRC_BRK = 1;
  localparam int SRC_CCH = 2;
  localparam int SRC_WAKE = 3;

  typedef struct packed {
    logic wake;
    logic ctrlChar;
    logic brkEdge;
    logic rxErr;
  } evtStrobes_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl #(
  parameter int DATA_W = 8,
  parameter int CTRL_MAX = 31,
  parameter int DEL_CODE = 127
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  parityErr,
  input  logic                  overrunErr,
  input  logic                  framingErr,
  input  logic                  breakLevel,
  input  logic [DATA_W-1:0]     rxByte,
  input  logic                  rxValid,
  input  logic                  wakeDetect,
  output uirq_pkg::evtStrobes_t strobes
);
  localparam logic [DATA_W-1:0] CtrlMax = DATA_W'(CTRL_MAX);
  localparam logic [DATA_W-1:0] DelCode = DATA_W'(DEL_CODE);

  logic prevBreak;
  logic isCtrl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevBreak <= 1'b0;
    else       prevBreak <= breakLevel;
  end

  assign isCtrl = (rxByte <= CtrlMax) || (rxByte == DelCode);

  always_comb begin
    strobes.rxErr    = parityErr | overrunErr | framingErr;
    strobes.brkEdge  = breakLevel ^ prevBreak;
    strobes.ctrlChar = rxValid & isCtrl;
    strobes.wake     = wakeDetect;
  end
endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath #(
  parameter int CTRL_W = 8,
  parameter int EN_LSB = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ctrlWe,
  input  logic [CTRL_W-1:0]             ctrlData,
  input  logic [uirq_pkg::NUM_SRC-1:0]  flagClr,
  input  uirq_pkg::evtStrobes_t         strobes,
  output logic [uirq_pkg::NUM_SRC-1:0]  flags,
  output logic [uirq_pkg::NUM_SRC-1:0]  enables,
  output logic                          irq
);
  localparam int NSrc = uirq_pkg::NUM_SRC;

  logic [NSrc-1:0] evtVec;
  assign evtVec = strobes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       enables <= '0;
    else if (ctrlWe) enables <= ctrlData[EN_LSB +: NSrc];
  end

  for (genvar s = 0; s < NSrc; s++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flags[s] <= 1'b0;
      else if (evtVec[s]) flags[s] <= 1'b1;
      else if (flagClr[s]) flags[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(flags & enables);
  end
endmodule

// File: rtl/uirq_rx_event.sv
module uirq_rx_event #(
  parameter int DATA_W = 8,
  parameter int EN_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [7:0]        ctrlData,
  input  logic [3:0]        flagClr,
  input  logic              parityErr,
  input  logic              overrunErr,
  input  logic              framingErr,
  input  logic              breakLevel,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              wakeDetect,
  output logic [3:0]        flags,
  output logic              irq
);
  uirq_pkg::evtStrobes_t strobes;
  logic [3:0] enables;

  uirq_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .parityErr(parityErr), .overrunErr(overrunErr), .framingErr(framingErr),
    .breakLevel(breakLevel), .rxByte(rxByte), .rxValid(rxValid),
    .wakeDetect(wakeDetect), .strobes(strobes)
  );

  uirq_datapath #(.CTRL_W(8), .EN_LSB(EN_LSB)) i_dp (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .flagClr(flagClr), .strobes(strobes), .flags(flags),
    .enables(enables), .irq(irq)
  );
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       parityErr,
  input logic       overrunErr,
  input logic       framingErr,
  input logic       breakLevel,
  input logic [7:0] rxByte,
  input logic       rxValid,
  input logic       wakeDetect,
  input logic [3:0] flagClr,
  input logic [3:0] flags,
  input logic [3:0] enables,
  input logic       irq
);
  logic shadowBrk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowBrk <= 1'b0;
    else       shadowBrk <= breakLevel;
  end

  a_r3_error_sets: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr | overrunErr | framingErr) |=> flags[0]);

  a_r4_break_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    (breakLevel != shadowBrk) |=> flags[1]);

  a_r5_ctrl_char_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (rxByte < 8'h20 || rxByte == 8'h7F)) |=> flags[2]);

  a_r6_wake_sets: assert property (@(posedge clk) disable iff (!rstN)
    wakeDetect |=> flags[3]);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !flagClr[0]) |=> flags[0]);

  a_r7_brk_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flags[1] && !flagClr[1]) |=> flags[1]);

  a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    (|(flags & enables)) |=> irq);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(|(flags & enables)) |=> !irq);
endmodule

bind uirq_rx_event uirq_checker i_chk (
  .clk(clk), .rstN(rstN), .parityErr(parityErr), .overrunErr(overrunErr),
  .framingErr(framingErr), .breakLevel(breakLevel), .rxByte(rxByte),
  .rxValid(rxValid), .wakeDetect(wakeDetect), .flagClr(flagClr),
  .flags(flags), .enables(enables), .irq(irq)
);

// File: tb/test_uirq_rx_event.sv
`timescale 1ns/1ps
module test_uirq_rx_event;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [7:0] ctrlData = '0;
  logic [3:0] flagClr = '0;
  logic parityErr = 1'b0, overrunErr = 1'b0, framingErr = 1'b0;
  logic breakLevel = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxValid = 1'b0;
  logic wakeDetect = 1'b0;
  logic [3:0] flags;
  logic irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [3:0] mFlags, mEn;
  logic mPrev, mIrq;

  always #4 clk = ~clk;

  uirq_rx_event i_uirq_rx_event (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .flagClr(flagClr), .parityErr(parityErr), .overrunErr(overrunErr),
    .framingErr(framingErr), .breakLevel(breakLevel), .rxByte(rxByte),
    .rxValid(rxValid), .wakeDetect(wakeDetect), .flags(flags), .irq(irq)
  );

  // Behavioural reference model
  always @(posedge clk or negedge rstN) begin
    logic [3:0] ev;
    if (!rstN) begin
      mFlags <= '0; mEn <= '0; mPrev <= 1'b0; mIrq <= 1'b0;
    end else begin
      ev[0] = parityErr | overrunErr | framingErr;
      ev[1] = (breakLevel !== mPrev);
      ev[2] = rxValid && ((rxByte < 8'd32) || (rxByte == 8'd127));
      ev[3] = wakeDetect;
      mIrq   <= (mFlags & mEn) != 0;
      mFlags <= (mFlags & ~flagClr) | ev;
      if (ctrlWe) mEn <= ctrlData[7:4];
      mPrev  <= breakLevel;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    string tags[4] = '{"R3", "R4", "R5", "R6"};
    for (int s = 0; s < 4; s++)
      check(flags[s] === mFlags[s], tags[s], flags[s], mFlags[s]);
    check(irq === mIrq, "R8", irq, mIrq);
  endtask

  task automatic tick();
    @(negedge clk);
    compareModel();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    check(flags === 4'h0, "R1", flags, 0);
    check(irq === 1'b0, "R1", irq, 0);

    // R2: enable error and ctrl-char sources, low bits junk
    ctrlWe = 1; ctrlData = 8'h5F;
    tick(); ctrlWe = 0; ctrlData = 0;

    wakeDetect = 1; tick(); wakeDetect = 0;
    check(flags === 4'b1000, "R6", flags, 4'b1000);
    tick();
    check(irq === 1'b0, "R9", irq, 0);

    rxValid = 1; rxByte = 8'h41; tick();
    check(flags === 4'b1000, "R5", flags, 4'b1000);
    rxByte = 8'h7F; tick(); rxValid = 0;
    check(flags === 4'b1100, "R5", flags, 4'b1100);
    tick();
    check(irq === 1'b1, "R8", irq, 1);

    flagClr = 4'b1111; overrunErr = 1; tick(); flagClr = 0; overrunErr = 0;
    check(flags === 4'b0001, "R7", flags, 4'b0001);
    tick();
    check(irq === 1'b1, "R3", irq, 1);

    flagClr = 4'b0001; tick(); flagClr = 0;
    check(flags === 4'b0000, "R7", flags, 0);
    breakLevel = 1; tick();
    check(flags === 4'b0010, "R4", flags, 4'b0010);
    flagClr = 4'b0010; tick(); flagClr = 0;
    check(flags === 4'b0000, "R7", flags, 0);
    breakLevel = 0; tick();
    check(flags === 4'b0010, "R4", flags, 4'b0010);
    tick();
    check(irq === 1'b0, "R9", irq, 0);

    ctrlWe = 1; ctrlData = 8'h20; tick(); ctrlWe = 0;
    check(irq === 1'b0, "R2", irq, 0);
    tick();
    check(irq === 1'b1, "R2", irq, 1);

    // Random phase, compared to the model every cycle
    for (int i = 0; i < 600; i++) begin
      parityErr  = ($urandom_range(0, 15) == 0);
      overrunErr = ($urandom_range(0, 19) == 0);
      framingErr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 9) == 0) breakLevel = ~breakLevel;
      rxValid = ($urandom_range(0, 3) == 0);
      rxByte = 8'($urandom_range(0, 255));
      wakeDetect = ($urandom_range(0, 24) == 0);
      flagClr = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      ctrlWe = ($urandom_range(0, 30) == 0);
      ctrlData = 8'($urandom_range(0, 255));
      tick();
    end
    finishRun();
  end
endmodule